// File: doc/BRIEF.md
# Flow-Through Burst SRAM Core With Zero Turnaround

This block is a synthesizable synchronous static memory with flow-through reads. It accepts a new command on every enabled clock edge, and reads and writes may follow each other in any order with no idle cycle between them. A command is taken when the advance/load control asks for a load and all three chip enables are active. A read returns its word in the cycle that follows the edge that captured its address. The data comes straight from the array, so no output register sits in the path. A write takes its data one enabled edge after its address, and that same edge updates the array under per-lane byte selects. Because a write's data arrives a cycle late, a write's data phase lines up with the slot where a read's data would appear, and so the shared data bus never has to turn around.

An access may be extended into a four-beat burst by holding the advance/load control high. The two low address bits then step in linear order or in interleaved order, as set by a mode input taken at load time. Deasserting the clock enable freezes the whole block. The data bus is modelled as separate input, output and drive-enable signals. The drive enable is also gated by an asynchronous active-low output enable.

Top module: `nds_sram`

## Requirements
- R1: After reset the block is deselected and `dq_oe` is 0 until a read is accepted.
- R2: A load (`adv_ld`=0) with chip enables active and `wr`=0 at edge k makes `dout` show the word at `addr`, with `dq_oe`=1 (when `oe_n`=0), in the cycle after edge k.
- R3: A load with `wr`=1 at edge k writes `din` sampled at the next enabled edge k+1 into the address captured at edge k.
- R4: During a write, byte lane i (bits 8i+7..8i of `din`) is stored only when `byte_sel[i]`=1. Unselected lanes keep their previous content.
- R5: A load is accepted only when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. Any other combination deselects, and `dq_oe` is then 0 in the next cycle.
- R6: With `ilv`=0 at load, each advance (`adv_ld`=1) moves the low two address bits to (start + n) mod 4. The upper bits are kept, and so are the read/write type and `ilv`.
- R7: With `ilv`=1 at load, the n-th beat of a burst uses low address bits start XOR n.
- R8: While `clk_en`=0 the edge is ignored. No command is taken, the array is unchanged, a pending write waits for the next enabled edge, and the outputs hold.
- R9: `oe_n`=1 forces `dq_oe` to 0 at once, without waiting for a clock edge.
- R10: `dq_oe` is 0 throughout the data phase of a write.
- R11: Reads and writes may alternate on every cycle. A read of an address loaded right after the write to that address returns the new data.
- R12: An advance issued while the block is deselected keeps it deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable; 0 freezes the block |
| adv_ld | input | 1 | 0 = load new command, 1 = advance burst |
| addr | input | ADDR_W | Word address |
| wr | input | 1 | 1 = write, 0 = read (sampled at load) |
| byte_sel | input | LANES | Per-lane write select, sampled with each write beat |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*LANE_W | Write data, one edge after the write address |
| dout | output | LANES*LANE_W | Read data, 0 when not driving |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
A fault in the command register shows at the ports in the cycle right after the edge that should have loaded it. It appears as a wrong `dq_oe` level, or as a read that returns the word from another address. A fault in the burst counter or in the ordering logic shows on the next beat as the wrong word, since every address in the array holds a distinct value. A write that lands on the wrong address or byte lane, or at the wrong edge, stays hidden until that location is read back. The sweeps therefore read every written location, and they do so both with back-to-back traffic and after idle and hold cycles.

// File: rtl/nds_pkg.sv
package nds_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } op_e;

  typedef enum logic {
    SEQ_LINEAR     = 1'b0,
    SEQ_INTERLEAVE = 1'b1
  } seq_e;
endpackage

// File: rtl/nds_ctrl.sv
module nds_ctrl #(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 2,
  parameter int BURST_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clk_en,
  input  logic                adv_ld,
  input  logic                ce_ok,
  input  logic                wr,
  input  logic                ilv,
  input  logic [LANES-1:0]    byte_sel,
  input  logic [ADDR_W-1:0]   addr,
  output logic                ph_act,
  output nds_pkg::op_e        ph_op,
  output nds_pkg::seq_e       ph_seq,
  output logic [LANES-1:0]    ph_be,
  output logic [ADDR_W-1:0]   ph_base,
  output logic [BURST_W-1:0]  ph_cnt
);
  import nds_pkg::*;

  logic               act_d;
  op_e                op_d;
  seq_e               seq_d;
  logic [LANES-1:0]   be_d;
  logic [ADDR_W-1:0]  base_d;
  logic [BURST_W-1:0] cnt_d;

  always_comb begin
    act_d  = ph_act;
    op_d   = ph_op;
    seq_d  = ph_seq;
    be_d   = ph_be;
    base_d = ph_base;
    cnt_d  = ph_cnt;
    if (!adv_ld) begin
      act_d = ce_ok;
      if (ce_ok) begin
        op_d   = wr ? OP_WRITE : OP_READ;
        seq_d  = ilv ? SEQ_INTERLEAVE : SEQ_LINEAR;
        be_d   = byte_sel;
        base_d = addr;
        cnt_d  = '0;
      end
    end else if (ph_act) begin
      cnt_d = ph_cnt + 1'b1;
      be_d  = byte_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_act  <= 1'b0;
      ph_op   <= OP_READ;
      ph_seq  <= SEQ_LINEAR;
      ph_be   <= '0;
      ph_base <= '0;
      ph_cnt  <= '0;
    end else if (clk_en) begin
      ph_act  <= act_d;
      ph_op   <= op_d;
      ph_seq  <= seq_d;
      ph_be   <= be_d;
      ph_base <= base_d;
      ph_cnt  <= cnt_d;
    end
  end
endmodule

// File: rtl/nds_burst_addr.sv
module nds_burst_addr #(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic [ADDR_W-1:0]  base,
  input  logic [BURST_W-1:0] cnt,
  input  nds_pkg::seq_e      seq,
  output logic [ADDR_W-1:0]  eff
);
  logic [BURST_W-1:0] lin_off;
  logic [BURST_W-1:0] ilv_off;

  assign lin_off = base[BURST_W-1:0] + cnt;
  assign ilv_off = base[BURST_W-1:0] ^ cnt;

  always_comb begin
    eff = base;
    eff[BURST_W-1:0] = (seq == nds_pkg::SEQ_INTERLEAVE) ? ilv_off : lin_off;
  end
endmodule

// File: rtl/nds_array.sv
module nds_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES-1:0]        be,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (we && be[g]) begin
        store[waddr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = store[raddr];
  end
endmodule

// File: rtl/nds_sram.sv
module nds_sram #(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 2,
  parameter int LANE_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en,
  input  logic                    adv_ld,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wr,
  input  logic [LANES-1:0]        byte_sel,
  input  logic                    ce_a_n,
  input  logic                    ce_b,
  input  logic                    ce_c_n,
  input  logic                    ilv,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dq_oe
);
  import nds_pkg::*;

  localparam int DATA_W = LANES * LANE_W;

  logic               ce_ok;
  logic               ph_act;
  op_e                ph_op;
  seq_e               ph_seq;
  logic [LANES-1:0]   ph_be;
  logic [ADDR_W-1:0]  ph_base;
  logic [BURST_W-1:0] ph_cnt;
  logic [ADDR_W-1:0]  eff_addr;
  logic [DATA_W-1:0]  rd_word;
  logic               wr_fire;
  logic               rd_phase;

  assign ce_ok = !ce_a_n && ce_b && !ce_c_n;

  nds_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .adv_ld(adv_ld),
    .ce_ok(ce_ok), .wr(wr), .ilv(ilv), .byte_sel(byte_sel), .addr(addr),
    .ph_act(ph_act), .ph_op(ph_op), .ph_seq(ph_seq), .ph_be(ph_be),
    .ph_base(ph_base), .ph_cnt(ph_cnt)
  );

  nds_burst_addr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_badr (
    .base(ph_base), .cnt(ph_cnt), .seq(ph_seq), .eff(eff_addr)
  );

  assign wr_fire = clk_en && ph_act && (ph_op == OP_WRITE);

  nds_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .we(wr_fire), .waddr(eff_addr), .be(ph_be), .wdata(din),
    .raddr(eff_addr), .rdata(rd_word)
  );

  assign rd_phase = ph_act && (ph_op == OP_READ);
  assign dq_oe    = rd_phase && !oe_n;
  assign dout     = dq_oe ? rd_word : '0;
endmodule

// File: rtl/nds_sram_chk.sv
module nds_sram_chk #(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              adv_ld,
  input logic              wr,
  input logic              ce_a_n,
  input logic              ce_b,
  input logic              ce_c_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic              ph_act,
  input logic              ph_seq,
  input logic [ADDR_W-1:0] eff_addr
);
  logic sel_ok;
  assign sel_ok = !ce_a_n && ce_b && !ce_c_n;

  a_r5_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && !adv_ld && !sel_ok |=> !dq_oe);

  a_r10_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && !adv_ld && sel_ok && wr |=> !dq_oe);

  a_r9_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(eff_addr) && $stable(ph_act));

  a_r6_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && adv_ld && ph_act && !ph_seq |=>
      eff_addr[BURST_W-1:0] == BURST_W'($past(eff_addr[BURST_W-1:0]) + 1'b1));

  a_r12_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && adv_ld && !ph_act |=> !ph_act);
endmodule

bind nds_sram nds_sram_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .adv_ld(adv_ld), .wr(wr),
  .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .oe_n(oe_n), .dq_oe(dq_oe),
  .ph_act(ph_act), .ph_seq(ph_seq), .eff_addr(eff_addr)
);

// File: tb/nds_sram_test.sv
module nds_sram_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n, clk_en, adv_ld, wr, ce_a_n, ce_b, ce_c_n, ilv, oe_n;
  logic [AW-1:0] addr;
  logic [1:0]    byte_sel;
  logic [15:0]   din, dout;
  logic          dq_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  logic [15:0] mem_m [DEPTH];
  bit          m_act = 0, m_wr = 0, m_il = 0;
  logic [AW-1:0] m_base = '0, m_addr = '0;
  int          m_n = 0;
  logic [1:0]  m_be = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nds_sram uut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .adv_ld(adv_ld), .addr(addr),
    .wr(wr), .byte_sel(byte_sel), .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
    .ilv(ilv), .oe_n(oe_n), .din(din), .dout(dout), .dq_oe(dq_oe)
  );

  function automatic logic [15:0] pat(int a, int salt);
    return 16'((a * 16'h0135) ^ (16'h5A3C + salt * 16'h1111));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    bit exp_oe;
    exp_oe = m_act && !m_wr && !oe_n;
    chk(cur_req, 32'(dq_oe), 32'(exp_oe));
    if (exp_oe && !$isunknown(mem_m[m_addr]))
      chk(cur_req, 32'(dout), 32'(mem_m[m_addr]));
  endtask

  // Reference: data phase of a write takes din at the next enabled edge;
  // burst low bits are (base+n) mod 4 or base^n.
  task automatic tick();
    if (clk_en) begin
      if (m_act && m_wr) begin
        if (m_be[0]) mem_m[m_addr][7:0]  = din[7:0];
        if (m_be[1]) mem_m[m_addr][15:8] = din[15:8];
      end
      if (!adv_ld) begin
        m_act = !ce_a_n && ce_b && !ce_c_n;
        if (m_act) begin
          m_wr = wr; m_base = addr; m_n = 0; m_il = ilv; m_be = byte_sel;
        end
      end else if (m_act) begin
        m_n++; m_be = byte_sel;
      end
      m_addr = {m_base[AW-1:2],
                m_il ? (m_base[1:0] ^ 2'(m_n)) : 2'(m_base[1:0] + 2'(m_n))};
    end
    @(posedge clk);
    @(negedge clk);
    check_outputs();
  endtask

  task automatic ld(bit w, int a, logic [1:0] bs, bit il, logic [15:0] d);
    clk_en = 1; adv_ld = 0; ce_a_n = 0; ce_b = 1; ce_c_n = 0;
    wr = w; addr = AW'(a); byte_sel = bs; ilv = il; din = d;
    tick();
  endtask

  task automatic adv(logic [1:0] bs, logic [15:0] d);
    clk_en = 1; adv_ld = 1; byte_sel = bs; din = d;
    addr = ~addr; wr = ~wr;
    tick();
  endtask

  task automatic desel(logic [15:0] d);
    clk_en = 1; adv_ld = 0; ce_a_n = 1; din = d;
    tick();
  endtask

  task automatic hold(logic [15:0] d);
    clk_en = 0; adv_ld = 0; ce_a_n = 0; ce_b = 1; ce_c_n = 0;
    wr = 1; addr = AW'(DEPTH - 1); byte_sel = 2'b11; din = d;
    tick();
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem_m[i] = 'x;
    rst_n = 0; clk_en = 1; adv_ld = 0; addr = '0; wr = 0; byte_sel = '0;
    ce_a_n = 1; ce_b = 0; ce_c_n = 1; ilv = 0; oe_n = 0; din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    chk("R1", 32'(dq_oe), 32'd0);
    adv(2'b00, 16'h0);
    chk("R1", 32'(dq_oe), 32'd0);

    // R3 R10: back-to-back write fill, drive stays off
    cur_req = "R10";
    for (int a = 0; a < DEPTH; a++) ld(1, a, 2'b11, 0, a == 0 ? 16'h0 : pat(a - 1, 0));
    desel(pat(DEPTH - 1, 0));

    // R2 R3: back-to-back read sweep
    cur_req = "R2";
    for (int a = 0; a < DEPTH; a++) ld(0, a, 2'b00, 0, 16'hFFFF);
    desel(16'h0);

    // R11: write then read same address, alternating every cycle
    cur_req = "R11";
    for (int a = 0; a < 16; a++) begin
      ld(1, a, 2'b11, 0, 16'hDEAD);
      ld(0, a, 2'b00, 0, pat(a, 3));
    end
    desel(16'h0);

    // R4: lane masks
    cur_req = "R4";
    for (int bs = 0; bs < 4; bs++) begin
      ld(1, 20, 2'(bs), 0, 16'h0);
      desel(pat(bs, 5));
      ld(0, 20, 2'b00, 0, 16'h0);
      desel(16'h0);
    end

    // R5 R12: chip-enable sweep, advance after each
    for (int c = 0; c < 8; c++) begin
      cur_req = "R5";
      clk_en = 1; adv_ld = 0; wr = 0; addr = 6'd5; ilv = 0;
      ce_a_n = c[0]; ce_b = c[1]; ce_c_n = c[2];
      tick();
      cur_req = "R12";
      adv(2'b00, 16'h0);
      adv(2'b00, 16'h0);
    end
    desel(16'h0);

    // R6 R7: burst reads and burst writes in both orders
    for (int il = 0; il < 2; il++) begin
      for (int b = 0; b < 4; b++) begin
        cur_req = (il == 0) ? "R6" : "R7";
        ld(0, 8 + b, 2'b00, il[0], 16'h0);
        repeat (3) adv(2'b00, 16'h0);
        ld(1, 40 + b, 2'b11, il[0], 16'h0);
        adv(2'b11, pat(b, 7 + il));
        adv(2'b01, pat(b, 9 + il));
        adv(2'b10, pat(b, 11 + il));
        desel(pat(b, 13 + il));
        ld(0, 40 + (b ^ 1), 2'b00, il[0], 16'h0);
        repeat (3) adv(2'b00, 16'h0);
        desel(16'h0);
      end
    end

    // R8: clock enable low holds read output, blocks commands, defers write data
    cur_req = "R8";
    ld(0, 7, 2'b00, 0, 16'h0);
    repeat (3) hold(16'hBEEF);
    ld(1, 9, 2'b11, 0, 16'h0);
    hold(16'hBAD0);
    hold(16'hBAD1);
    desel(16'h4C2B);
    ld(0, 9, 2'b00, 0, 16'h0);
    ld(0, 63, 2'b00, 0, 16'h0);
    desel(16'h0);

    // R9: asynchronous output enable
    cur_req = "R9";
    ld(0, 3, 2'b00, 0, 16'h0);
    oe_n = 1; #1;
    chk("R9", 32'(dq_oe), 32'd0);
    oe_n = 0; #1;
    chk("R9", 32'(dq_oe), 32'd1);
    chk("R9", 32'(dout), 32'(mem_m[3]));
    desel(16'h0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule